// File: doc/BRIEF.md
# Compressed Displacement Scaling Unit

This stage sits in a vector instruction decoder, right after the memory-operand bytes have been parsed. It receives the displacement field of a register/memory operand. That field is either an 8-bit short displacement or a full-width one. The stage then produces the effective displacement that address generation will add. Under the extended vector prefix, a short displacement is no longer a plain byte offset. It counts units of N bytes, where N follows from the operand's tuple class, the vector length, the broadcast bit and the element-width bit. Several special operand kinds replace the class rule with their own factor.

Because every N is a power of two, the stage picks a shift distance instead of a multiplier. It sign-extends the byte, shifts it left, and truncates the result to 16 bits when the address size is 16. The result is registered, so it appears one cycle after the input strobe, along with a flag that marks a quarter-class or eighth-class operand seen without broadcast.

Top module: `disp_scale_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low otherwise. After reset, `out_valid`, `disp_out` and `tuple_err` are all 0.
- R2: When `disp8_flag` is 0, the full displacement `disp_raw` passes through unscaled (32/64-bit address size: `addr_size` 1 or 2; code 3 behaves as 32-bit).
- R3: When `disp8_flag` is 1 and `ext_prefix` is 0, the output is `disp_raw[7:0]` sign-extended to 32 bits (N=1). The upper bits of `disp_raw` are ignored.
- R4: Full-vector class (`tuple_cls`=0): N = 4<<`elem_w` when `bcast`=1. Otherwise N = 16·M, where M is 1, 2 or 4 for `vec_len` 0 (128), 1 (256) or 2 (512); `vec_len` 3 uses M=4.
- R5: Scalar class (`tuple_cls`=1): N = 4<<`elem_w`.
- R6: Half-vector class (`tuple_cls`=2): N = 4<<`elem_w` when `bcast`=1, else N = 8·M.
- R7: Quarter class (`tuple_cls`=3): N = 4·M. Eighth class (`tuple_cls`=4): N = 2·M. Both hold whatever `bcast` is.
- R8: Fixed classes: `tuple_cls`=5 gives N=16, `tuple_cls`=6 gives N=32, and `tuple_cls`=7 gives N=1.
- R9: With `dup_flag`=1 and `vec_len`=0, N=8 regardless of class. At other lengths `dup_flag` has no effect.
- R10: With `vsib_flag`=1, N = 4<<`elem_w`. This overrides `gpr_flag`, `dup_flag` and the class (priority: vector index, then general register, then duplicate-move, then class).
- R11: With `gpr_flag`=1 (and `vsib_flag`=0), N=4 for 32-bit data (`elem_w`=0) and N=8 for 64-bit data (`elem_w`=1).
- R12: When `addr_size`=0 (16-bit), `disp_out` = {16'b0, result[15:0]}, for both scaled and full displacements.
- R13: `tuple_err` is 1 together with the result when a scaled short displacement takes the class path with class 3 or 4 and `bcast`=0. The length-based result is still produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input operand strobe |
| disp_raw | input | 32 | Displacement field; the low byte is used when short |
| disp8_flag | input | 1 | Displacement came from the 8-bit form |
| ext_prefix | input | 1 | Instruction carries the extended vector prefix |
| addr_size | input | 2 | 0=16-bit, 1=32-bit, 2=64-bit |
| tuple_cls | input | 3 | Operand tuple class code |
| vec_len | input | 2 | 0=128, 1=256, 2=512 bits |
| bcast | input | 1 | Broadcast bit |
| elem_w | input | 1 | Element-width bit (0=32-bit, 1=64-bit) |
| vsib_flag | input | 1 | Operand uses a vector-index memory form |
| gpr_flag | input | 1 | Operand is a general-register memory operand |
| dup_flag | input | 1 | Duplicate-move opcode |
| out_valid | output | 1 | Result strobe |
| disp_out | output | 32 | Effective displacement |
| tuple_err | output | 1 | Quarter/eighth class without broadcast |

## Verification
The bench targets the places where a wrong design would still look plausible. A negative byte scaled by a large factor catches a zero-extended byte, because that error gives a large positive offset. A 16-bit address size with a scaled negative value catches missing truncation or truncation with sign fill. Override combinations are driven together, such as a vector index with the duplicate-move flag at 128 bits, or duplicate-move at 512 bits. These catch a wrong priority order or an override that ignores the vector length, since each of those gives a different power of two. Back-to-back strobes with idle gaps between them expose a result that is late by one cycle or that stays valid too long.

// File: rtl/disp_scale_pkg.sv
package disp_scale_pkg;

    localparam int DISP_W  = 32;
    localparam int SHAMT_W = 3;

    typedef enum logic [2:0] {
        TC_FULL    = 3'd0,
        TC_SCALAR  = 3'd1,
        TC_HALF    = 3'd2,
        TC_QUARTER = 3'd3,
        TC_EIGHTH  = 3'd4,
        TC_FIX128  = 3'd5,
        TC_FIX256  = 3'd6,
        TC_NONE    = 3'd7
    } tuple_e;

    typedef enum logic [1:0] {
        AS_16   = 2'd0,
        AS_32   = 2'd1,
        AS_64   = 2'd2,
        AS_RSVD = 2'd3
    } asize_e;

    // which rule supplies the scale factor
    typedef enum logic [2:0] {
        SRC_UNIT,
        SRC_VSIB,
        SRC_GPR,
        SRC_DUP,
        SRC_CLASS
    } factor_src_e;

endpackage

// File: rtl/disp_scale_factor.sv
module disp_scale_factor
    import disp_scale_pkg::*;
#(
    parameter int SH_W = SHAMT_W
) (
    input  logic            ext_prefix,
    input  logic            disp8_flag,
    input  logic [2:0]      tuple_cls,
    input  logic [1:0]      vec_len,
    input  logic            bcast,
    input  logic            elem_w,
    input  logic            vsib_flag,
    input  logic            gpr_flag,
    input  logic            dup_flag,
    output logic [SH_W-1:0] shamt,
    output logic            err
);

    localparam logic [SH_W-1:0] LOG_ELEM = SH_W'(2);

    factor_src_e     src;
    logic [SH_W-1:0] len_log;
    logic [SH_W-1:0] w_log;
    logic [SH_W-1:0] class_sh;
    logic            class_err;

    // vector length multiplier as log2; reserved code treated as widest
    always_comb begin
        len_log = (vec_len[1]) ? SH_W'(2) : SH_W'(vec_len[0]);
        w_log   = LOG_ELEM + SH_W'(elem_w);
    end

    // override priority selection
    always_comb begin
        if (!(disp8_flag && ext_prefix))
            src = SRC_UNIT;
        else if (vsib_flag)
            src = SRC_VSIB;
        else if (gpr_flag)
            src = SRC_GPR;
        else if (dup_flag && vec_len == 2'd0)
            src = SRC_DUP;
        else
            src = SRC_CLASS;
    end

    always_comb begin
        class_err = 1'b0;
        unique case (tuple_e'(tuple_cls))
            TC_FULL:    class_sh = bcast ? w_log : SH_W'(4) + len_log;
            TC_SCALAR:  class_sh = w_log;
            TC_HALF:    class_sh = bcast ? w_log : SH_W'(3) + len_log;
            TC_QUARTER: begin
                class_sh  = SH_W'(2) + len_log;
                class_err = !bcast;
            end
            TC_EIGHTH:  begin
                class_sh  = SH_W'(1) + len_log;
                class_err = !bcast;
            end
            TC_FIX128:  class_sh = SH_W'(4);
            TC_FIX256:  class_sh = SH_W'(5);
            TC_NONE:    class_sh = SH_W'(0);
        endcase
    end

    always_comb begin
        shamt = '0;
        err   = 1'b0;
        unique case (src)
            SRC_UNIT:  shamt = '0;
            SRC_VSIB:  shamt = w_log;
            SRC_GPR:   shamt = w_log;
            SRC_DUP:   shamt = SH_W'(3);
            SRC_CLASS: begin
                shamt = class_sh;
                err   = class_err;
            end
            default:   shamt = '0;
        endcase
    end

endmodule

// File: rtl/disp_scale_shifter.sv
module disp_scale_shifter
    import disp_scale_pkg::*;
#(
    parameter int W    = DISP_W,
    parameter int SH_W = SHAMT_W
) (
    input  logic [W-1:0]    disp_raw,
    input  logic            disp8_flag,
    input  logic [SH_W-1:0] shamt,
    input  logic            addr16,
    output logic [W-1:0]    disp_next
);

    localparam int SHORT_W = 8;
    localparam int HALF_W  = 16;

    logic [W-1:0] sext;
    logic [W-1:0] wide;

    always_comb begin
        sext = {{(W-SHORT_W){disp_raw[SHORT_W-1]}}, disp_raw[SHORT_W-1:0]};
        wide = disp8_flag ? (sext << shamt) : disp_raw;
        if (addr16)
            disp_next = {{(W-HALF_W){1'b0}}, wide[HALF_W-1:0]};
        else
            disp_next = wide;
    end

endmodule

// File: rtl/disp_scale_unit.sv
module disp_scale_unit
    import disp_scale_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] disp_raw,
    input  logic        disp8_flag,
    input  logic        ext_prefix,
    input  logic [1:0]  addr_size,
    input  logic [2:0]  tuple_cls,
    input  logic [1:0]  vec_len,
    input  logic        bcast,
    input  logic        elem_w,
    input  logic        vsib_flag,
    input  logic        gpr_flag,
    input  logic        dup_flag,
    output logic        out_valid,
    output logic [31:0] disp_out,
    output logic        tuple_err
);

    logic [SHAMT_W-1:0] shamt;
    logic               err_c;
    logic [DISP_W-1:0]  disp_c;
    logic               addr16;

    assign addr16 = (asize_e'(addr_size) == AS_16);

    disp_scale_factor #(.SH_W(SHAMT_W)) u_factor (
        .ext_prefix (ext_prefix),
        .disp8_flag (disp8_flag),
        .tuple_cls  (tuple_cls),
        .vec_len    (vec_len),
        .bcast      (bcast),
        .elem_w     (elem_w),
        .vsib_flag  (vsib_flag),
        .gpr_flag   (gpr_flag),
        .dup_flag   (dup_flag),
        .shamt      (shamt),
        .err        (err_c)
    );

    disp_scale_shifter #(.W(DISP_W), .SH_W(SHAMT_W)) u_shift (
        .disp_raw   (disp_raw),
        .disp8_flag (disp8_flag),
        .shamt      (shamt),
        .addr16     (addr16),
        .disp_next  (disp_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            disp_out  <= '0;
            tuple_err <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                disp_out  <= disp_c;
                tuple_err <= err_c;
            end else begin
                tuple_err <= 1'b0;
            end
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !disp8_flag && addr_size != 2'd0) |=> disp_out == $past(disp_raw));
    // R12
    addr16_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && addr_size == 2'd0) |=> disp_out[31:16] == 16'h0);
    // R3
    short_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && disp8_flag && addr_size != 2'd0) |=> disp_out[31] == $past(disp_raw[7]));
    // R13
    err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tuple_err |-> out_valid);
    // R13
    err_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bcast) |=> !tuple_err);

endmodule

// File: tb/disp_scale_unit_bench.sv
module disp_scale_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] disp_raw = '0;
    logic        disp8_flag = 1'b0;
    logic        ext_prefix = 1'b0;
    logic [1:0]  addr_size = 2'd1;
    logic [2:0]  tuple_cls = '0;
    logic [1:0]  vec_len = '0;
    logic        bcast = 1'b0;
    logic        elem_w = 1'b0;
    logic        vsib_flag = 1'b0;
    logic        gpr_flag = 1'b0;
    logic        dup_flag = 1'b0;
    logic        out_valid;
    logic [31:0] disp_out;
    logic        tuple_err;

    typedef struct {
        logic [31:0] disp;
        logic        err;
        int          due;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    disp_scale_unit u_disp_scale_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .disp_raw(disp_raw),
        .disp8_flag(disp8_flag), .ext_prefix(ext_prefix), .addr_size(addr_size),
        .tuple_cls(tuple_cls), .vec_len(vec_len), .bcast(bcast), .elem_w(elem_w),
        .vsib_flag(vsib_flag), .gpr_flag(gpr_flag), .dup_flag(dup_flag),
        .out_valid(out_valid), .disp_out(disp_out), .tuple_err(tuple_err)
    );

    function automatic int factor(input logic d8, input logic ev, input int cls,
                                  input int vl, input logic bc, input logic w,
                                  input logic vs, input logic gp, input logic dp);
        int m;
        int ew;
        m  = (vl == 0) ? 1 : (vl == 1) ? 2 : 4;
        ew = w ? 8 : 4;
        if (!(d8 && ev)) return 1;
        if (vs) return ew;
        if (gp) return ew;
        if (dp && vl == 0) return 8;
        case (cls)
            0: return bc ? ew : 16 * m;
            1: return ew;
            2: return bc ? ew : 8 * m;
            3: return 4 * m;
            4: return 2 * m;
            5: return 16;
            6: return 32;
            default: return 1;
        endcase
    endfunction

    task automatic drive(input logic [31:0] raw, input logic d8, input logic ev,
                         input int as, input int cls, input int vl,
                         input logic bc, input logic w, input logic vs,
                         input logic gp, input logic dp, input string tag);
        exp_t e;
        int   n;
        int   s;
        logic [31:0] v;
        @(negedge clk);
        in_valid = 1'b1; disp_raw = raw; disp8_flag = d8; ext_prefix = ev;
        addr_size = 2'(as); tuple_cls = 3'(cls); vec_len = 2'(vl); bcast = bc;
        elem_w = w; vsib_flag = vs; gpr_flag = gp; dup_flag = dp;
        n = factor(d8, ev, cls, vl, bc, w, vs, gp, dp);
        if (d8) begin
            s = int'($signed(raw[7:0]));
            v = 32'(s * n);
        end else begin
            v = raw;
        end
        if (as == 0) v = {16'h0, v[15:0]};
        e.disp = v;
        e.err  = d8 && ev && !vs && !gp && !(dp && vl == 0) && (cls == 3 || cls == 4) && !bc;
        e.due  = cyc + 1;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pops expected items when the design produces them
    always @(negedge clk) begin
        if (mon_on) begin
            logic want;
            want = (q.size() > 0) && (q[0].due == cyc);
            checks++;
            if (out_valid !== want) begin
                fails++;
                $display("FAIL R1 out_valid actual=%0b expected=%0b cycle=%0d", out_valid, want, cyc);
            end
            if (want) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (disp_out !== e.disp || tuple_err !== e.err) begin
                    fails++;
                    $display("FAIL %s disp/err actual=%h/%0b expected=%h/%0b",
                             e.tag, disp_out, tuple_err, e.disp, e.err);
                end
            end
        end
    end

    initial begin
        fork
            begin
                repeat (WATCHDOG) @(posedge clk);
                fails++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        join_none

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || disp_out !== 32'h0 || tuple_err !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual=%0b/%h/%0b expected=0/0/0", out_valid, disp_out, tuple_err);
        end
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R2 full displacement pass-through
        drive(32'h1234_5678, 0, 1, 1, 0, 2, 0, 0, 0, 0, 0, "R2");
        drive(32'hFFFF_FF80, 0, 1, 2, 3, 2, 0, 1, 0, 0, 0, "R2");
        drive(32'h0000_0100, 0, 1, 3, 0, 2, 0, 0, 0, 0, 0, "R2");
        idle(2);
        // R3 short displacement without extended prefix
        drive(32'h0000_0080, 1, 0, 1, 0, 2, 0, 0, 0, 0, 0, "R3");
        drive(32'hABCD_00FF, 1, 0, 2, 1, 1, 0, 1, 0, 0, 0, "R3");
        // R4 full vector
        drive(32'h0000_0001, 1, 1, 1, 0, 2, 0, 0, 0, 0, 0, "R4");
        drive(32'h0000_00FF, 1, 1, 1, 0, 1, 0, 0, 0, 0, 0, "R4");
        drive(32'h0000_0002, 1, 1, 2, 0, 2, 1, 1, 0, 0, 0, "R4");
        drive(32'h0000_0003, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
        drive(32'h0000_0001, 1, 1, 1, 0, 3, 0, 0, 0, 0, 0, "R4");
        idle(1);
        // R5 scalar
        drive(32'h0000_0005, 1, 1, 1, 1, 2, 0, 0, 0, 0, 0, "R5");
        drive(32'h0000_0080, 1, 1, 2, 1, 0, 0, 1, 0, 0, 0, "R5");
        // R6 half vector
        drive(32'h0000_0001, 1, 1, 1, 2, 2, 0, 0, 0, 0, 0, "R6");
        drive(32'h0000_0001, 1, 1, 1, 2, 2, 1, 0, 0, 0, 0, "R6");
        drive(32'h0000_00F0, 1, 1, 1, 2, 0, 0, 1, 0, 0, 0, "R6");
        // R7 quarter and eighth with broadcast
        drive(32'h0000_0001, 1, 1, 1, 3, 1, 1, 0, 0, 0, 0, "R7");
        drive(32'h0000_007F, 1, 1, 1, 4, 2, 1, 1, 0, 0, 0, "R7");
        // R8 fixed classes and unused code
        drive(32'h0000_0001, 1, 1, 1, 5, 0, 0, 1, 0, 0, 0, "R8");
        drive(32'h0000_00FF, 1, 1, 1, 6, 2, 1, 0, 0, 0, 0, "R8");
        drive(32'h0000_0040, 1, 1, 1, 7, 2, 0, 1, 0, 0, 0, "R8");
        idle(3);
        // R9 duplicate-move override only at 128 bits
        drive(32'h0000_0001, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1, "R9");
        drive(32'h0000_0001, 1, 1, 1, 0, 2, 0, 0, 0, 0, 1, "R9");
        // R10 vector index beats every other rule
        drive(32'h0000_0001, 1, 1, 1, 0, 0, 0, 1, 1, 1, 1, "R10");
        drive(32'h0000_0081, 1, 1, 1, 3, 2, 0, 0, 1, 0, 0, "R10");
        // R11 general-register operand
        drive(32'h0000_0001, 1, 1, 2, 0, 2, 0, 1, 0, 1, 1, "R11");
        drive(32'h0000_00FF, 1, 1, 1, 6, 2, 0, 0, 0, 1, 0, "R11");
        // R12 16-bit truncation
        drive(32'h0000_0080, 1, 1, 0, 0, 2, 0, 0, 0, 0, 0, "R12");
        drive(32'h1234_ABCD, 0, 1, 0, 0, 2, 0, 0, 0, 0, 0, "R12");
        drive(32'h0000_00FF, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
        // R13 quarter/eighth without broadcast
        drive(32'h0000_0001, 1, 1, 1, 3, 2, 0, 0, 0, 0, 0, "R13");
        drive(32'h0000_0001, 1, 1, 1, 4, 0, 0, 1, 0, 0, 0, "R13");
        drive(32'h0000_0001, 1, 0, 1, 3, 2, 0, 0, 0, 0, 0, "R13");
        idle(4);

        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R1 leftover results actual=%0d expected=0", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule